// File: doc/BRIEF.md
# Peripheral DMA Engine with Double-Buffered Channel Descriptors

This block moves data words between on-chip serial peripherals and system memory through one bus master port. There are several channels, and each one moves data in a single direction, fixed at build time: either memory to peripheral (transmit) or peripheral to memory (receive). Each channel keeps two descriptors, and a descriptor is a 32-bit memory pointer with a 16-bit item counter. The active descriptor is being worked on. The standby descriptor is promoted into the active slot as soon as the active counter runs out, so software can queue the following buffer early and the stream does not stall while it waits for service.

A peripheral asks for service by holding its request line high. The engine grants the master port to one eligible channel at a time. Among the pending channels, the highest-numbered one wins. Arbitration only takes place between whole item moves. A transmit item takes one bus cycle: the memory read data goes to the peripheral in the same cycle. A receive item takes two cycles: the engine first captures the peripheral word, then writes it to memory. For each channel the engine drives two level flags. One shows that the active buffer is finished. The other shows that both descriptors are used up.

Top module: `pbuf_dma`

## Requirements
- R1: After reset, every pointer, counter and control field reads zero, every channel is disabled, both status flags of every channel are high, and no bus read, bus write or acknowledge is driven.
- R2: A configuration write chooses a channel with `cfg_ch` and a field with `cfg_sel`. The codes are 0 active pointer, 1 active counter (low 16 bits), 2 standby pointer, 3 standby counter (low 16 bits), and 4 control (bit 0 enable, bits 2:1 item size). The write takes effect at the clock edge. `cfg_rdata` returns the selected field combinationally, and any other code reads zero.
- R3: A transmit item takes exactly one cycle. In that cycle `mem_rd` is high, `mem_addr` equals the active pointer, `mem_size` equals the size code, `per_tx_data` equals `mem_rdata`, and only the granted channel's `per_ack` bit is high.
- R4: A receive item takes two consecutive cycles. In the first cycle the channel's `per_ack` bit pulses and its `per_rx_data` word is captured, with no bus access. In the second cycle `mem_wr` writes the captured word to the active pointer. No other channel is acknowledged in the second cycle.
- R5: After each item the active pointer advances by the item size: code 0 adds 1 byte, code 1 adds 2 and code 2 adds 4, and code 3 behaves like code 2. The active counter drops by one.
- R6: When the active counter is zero and the standby counter is nonzero, the standby pointer and counter are copied into the active set at the same clock edge, and the standby counter becomes zero. This holds whether the active counter reached zero through an item or the standby counter was written while the active counter was already zero.
- R7: `eot[i]` is high exactly while channel i's active counter is zero. `buf_idle[i]` is high exactly while both of its counters are zero.
- R8: When several channels are eligible in the same cycle, the one with the highest index is served.
- R9: Clearing a channel's enable stops new items on that channel, but a receive item already started completes its memory write. The pointers and counters are kept.
- R10: A request from a channel that is disabled, or whose active counter is zero, produces no acknowledge and no bus access.
- R11: Writes to the standby pointer or counter are accepted while the channel is transferring, and they do not disturb the item in progress or the active set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_ch | input | IW | Channel chosen for write and read |
| cfg_sel | input | 3 | Field code (see R2) |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Selected field read data |
| per_req | input | NCH | Peripheral request per channel, held high while an item is wanted |
| per_ack | output | NCH | One-cycle acknowledge per item, one-hot or zero |
| per_tx_data | output | 32 | Word delivered to a transmit peripheral |
| per_rx_data | input | NCH*32 | Word offered by each receive peripheral, channel i at bits i*32 upward |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_addr | output | 32 | Memory byte address |
| mem_size | output | 2 | Item size code of the access |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid in the same cycle |
| eot | output | NCH | Active buffer finished, per channel |
| buf_idle | output | NCH | Both descriptors exhausted, per channel |

## Verification
On every cycle the embedded properties check the following. Acknowledges are one-hot. Reads and writes never overlap. Only eligible channels are acknowledged. The grant goes to the top-ranked requester. A receive capture is always followed by its write for the same channel. Counters step by one with the pointer step that matches the size. A nonzero standby counter never sits behind an empty active counter. Some behaviour depends on sequences of register writes and requests, and only the bench scenarios show it: the exact addresses and data words seen on the bus, the final pointer for each item size, promotion timing, a disable landing in the middle of a receive item, and standby writes that overlap a live transfer.

// File: rtl/pbd_pkg.sv
package pbd_pkg;
  localparam int PTR_W  = 32;
  localparam int CNT_W  = 16;
  localparam int DATA_W = 32;

  typedef logic [PTR_W-1:0]  ptr_t;
  typedef logic [CNT_W-1:0]  cnt_t;
  typedef logic [DATA_W-1:0] word_t;

  typedef enum logic [2:0] {
    SEL_CUR_PTR = 3'd0,
    SEL_CUR_CNT = 3'd1,
    SEL_NXT_PTR = 3'd2,
    SEL_NXT_CNT = 3'd3,
    SEL_CTRL    = 3'd4
  } sel_e;

  typedef struct packed {
    ptr_t       cur_ptr;
    cnt_t       cur_cnt;
    ptr_t       nxt_ptr;
    cnt_t       nxt_cnt;
    logic       en;
    logic [1:0] size;
  } chan_regs_t;

  // bytes covered by one item for a size code
  function automatic ptr_t step_bytes(input logic [1:0] size);
    case (size)
      2'd0:    return ptr_t'(1);
      2'd1:    return ptr_t'(2);
      default: return ptr_t'(4);
    endcase
  endfunction

  function automatic ptr_t advance(input ptr_t p, input logic [1:0] size);
    return p + step_bytes(size);
  endfunction

  function automatic word_t ctrl_word(input logic en, input logic [1:0] size);
    return word_t'({size, en});
  endfunction
endpackage

// File: rtl/pbd_chan.sv
module pbd_chan
  import pbd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [2:0] wr_sel,
  input  word_t      wr_data,
  input  logic       item_done,
  output chan_regs_t regs
);
  chan_regs_t regs_q, regs_d;
  logic       promote;

  always_comb begin
    regs_d = regs_q;
    if (item_done) begin
      regs_d.cur_ptr = advance(regs_q.cur_ptr, regs_q.size);
      if (regs_q.cur_cnt != '0) regs_d.cur_cnt = regs_q.cur_cnt - 1'b1;
    end
    if (wr_en) begin
      case (wr_sel)
        SEL_CUR_PTR: regs_d.cur_ptr = wr_data;
        SEL_CUR_CNT: regs_d.cur_cnt = wr_data[CNT_W-1:0];
        SEL_NXT_PTR: regs_d.nxt_ptr = wr_data;
        SEL_NXT_CNT: regs_d.nxt_cnt = wr_data[CNT_W-1:0];
        SEL_CTRL: begin
          regs_d.en   = wr_data[0];
          regs_d.size = wr_data[2:1];
        end
        default: ;
      endcase
    end
    promote = (regs_d.cur_cnt == '0) && (regs_d.nxt_cnt != '0);
    if (promote) begin
      regs_d.cur_ptr = regs_d.nxt_ptr;
      regs_d.cur_cnt = regs_d.nxt_cnt;
      regs_d.nxt_cnt = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) regs_q <= '0;
    else        regs_q <= regs_d;
  end

  assign regs = regs_q;

  // R5: an item moves the pointer by one size step and the counter by one
  p_count_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (item_done && !wr_en && regs_q.cur_cnt > cnt_t'(1)) |=>
      (regs_q.cur_cnt == $past(regs_q.cur_cnt) - 1'b1) &&
      (regs_q.cur_ptr == $past(regs_q.cur_ptr) + step_bytes($past(regs_q.size))));

  // R6: the last item of the active buffer brings in the standby set
  p_promote_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (item_done && !wr_en && regs_q.cur_cnt == cnt_t'(1) && regs_q.nxt_cnt != '0) |=>
      (regs_q.cur_ptr == $past(regs_q.nxt_ptr)) &&
      (regs_q.cur_cnt == $past(regs_q.nxt_cnt)) && (regs_q.nxt_cnt == '0));

  // R6: a loaded standby set never waits behind an empty active set
  p_no_stale_next_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (regs_q.cur_cnt == '0) |-> (regs_q.nxt_cnt == '0));

  // R9: with no item and no write the descriptors stay put
  p_hold_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!item_done && !wr_en) |=> $stable(regs_q));
endmodule

// File: rtl/pbd_arb.sv
module pbd_arb #(
  parameter int unsigned NCH = 4,
  localparam int unsigned IW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] elig,
  output logic           gnt_vld,
  output logic [IW-1:0]  gnt_idx
);
  always_comb begin
    gnt_vld = 1'b0;
    gnt_idx = '0;
    for (int i = 0; i < NCH; i++) begin
      if (elig[i]) begin
        gnt_vld = 1'b1;
        gnt_idx = IW'(i);
      end
    end
  end

  // R8: the granted channel is eligible and no higher channel is
  p_top_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_vld |-> ((elig >> gnt_idx) == NCH'(1)));

  // R10: a grant appears exactly when some channel is eligible
  p_grant_needs_elig_r10: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_vld == (elig != '0));
endmodule

// File: rtl/pbd_seq.sv
module pbd_seq
  import pbd_pkg::*;
#(
  parameter int unsigned    NCH     = 4,
  parameter logic [NCH-1:0] RX_MASK = '0,
  localparam int unsigned   IW      = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           gnt_vld,
  input  logic [IW-1:0]  gnt_idx,
  input  word_t          rx_word,
  input  ptr_t           act_ptr,
  input  logic [1:0]     act_size,
  output logic [IW-1:0]  act_idx,
  output logic [NCH-1:0] per_ack,
  output logic [NCH-1:0] item_done,
  output word_t          per_tx_data,
  output logic           mem_rd,
  output logic           mem_wr,
  output ptr_t           mem_addr,
  output logic [1:0]     mem_size,
  output word_t          mem_wdata,
  input  word_t          mem_rdata
);
  logic          wr_phase_q;
  logic [IW-1:0] owner_q;
  word_t         hold_q;
  logic          start_rx;
  logic          start_tx;
  logic          bus_busy;

  assign start_rx = !wr_phase_q && gnt_vld &&  RX_MASK[gnt_idx];
  assign start_tx = !wr_phase_q && gnt_vld && !RX_MASK[gnt_idx];

  always_comb begin
    per_ack   = '0;
    item_done = '0;
    act_idx   = wr_phase_q ? owner_q : gnt_idx;
    mem_rd    = start_tx;
    mem_wr    = wr_phase_q;
    if (wr_phase_q) begin
      item_done[owner_q] = 1'b1;
    end else if (gnt_vld) begin
      per_ack[gnt_idx] = 1'b1;
      if (start_tx) item_done[gnt_idx] = 1'b1;
    end
  end

  assign bus_busy    = mem_rd || mem_wr;
  assign mem_addr    = bus_busy ? act_ptr  : '0;
  assign mem_size    = bus_busy ? act_size : 2'd0;
  assign mem_wdata   = wr_phase_q ? hold_q : '0;
  assign per_tx_data = mem_rd ? mem_rdata : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_phase_q <= 1'b0;
      owner_q    <= '0;
      hold_q     <= '0;
    end else if (start_rx) begin
      wr_phase_q <= 1'b1;
      owner_q    <= gnt_idx;
      hold_q     <= rx_word;
    end else begin
      wr_phase_q <= 1'b0;
    end
  end

  // R4: a receive capture is followed by the write of that channel's word
  p_rx_second_phase_r4: assert property (@(posedge clk) disable iff (!rst_n)
    start_rx |=> (mem_wr && per_ack == '0 && act_idx == $past(gnt_idx) &&
                  mem_wdata == $past(rx_word)));

  // R3: the port never reads and writes in one cycle
  p_bus_exclusive_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));

  // R3: a transmit read completes its item in the same cycle
  p_tx_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |-> ($onehot(per_ack) && item_done == per_ack));

  // R8: at most one channel is acknowledged per cycle
  p_ack_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(per_ack));
endmodule

// File: rtl/pbuf_dma.sv
module pbuf_dma
  import pbd_pkg::*;
#(
  parameter int unsigned    NCH     = 4,
  parameter logic [NCH-1:0] RX_MASK = 4'b1010,
  localparam int unsigned   IW      = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic [IW-1:0]       cfg_ch,
  input  logic [2:0]          cfg_sel,
  input  logic [31:0]         cfg_wdata,
  output logic [31:0]         cfg_rdata,
  input  logic [NCH-1:0]      per_req,
  output logic [NCH-1:0]      per_ack,
  output logic [31:0]         per_tx_data,
  input  logic [NCH*32-1:0]   per_rx_data,
  output logic                mem_rd,
  output logic                mem_wr,
  output logic [31:0]         mem_addr,
  output logic [1:0]          mem_size,
  output logic [31:0]         mem_wdata,
  input  logic [31:0]         mem_rdata,
  output logic [NCH-1:0]      eot,
  output logic [NCH-1:0]      buf_idle
);
  chan_regs_t     regs [NCH];
  logic [NCH-1:0] item_done;
  logic [NCH-1:0] elig;
  logic           gnt_vld;
  logic [IW-1:0]  gnt_idx;
  logic [IW-1:0]  act_idx;
  word_t          rx_word;
  chan_regs_t     rd_regs;

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    pbd_chan u_chan (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (cfg_we && (cfg_ch == IW'(g))),
      .wr_sel    (cfg_sel),
      .wr_data   (cfg_wdata),
      .item_done (item_done[g]),
      .regs      (regs[g])
    );
    assign elig[g]     = per_req[g] && regs[g].en && (regs[g].cur_cnt != '0);
    assign eot[g]      = (regs[g].cur_cnt == '0);
    assign buf_idle[g] = (regs[g].cur_cnt == '0) && (regs[g].nxt_cnt == '0);
  end

  pbd_arb #(.NCH(NCH)) u_arb (
    .clk     (clk),
    .rst_n   (rst_n),
    .elig    (elig),
    .gnt_vld (gnt_vld),
    .gnt_idx (gnt_idx)
  );

  assign rx_word = per_rx_data[gnt_idx*DATA_W +: DATA_W];

  pbd_seq #(.NCH(NCH), .RX_MASK(RX_MASK)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .gnt_vld     (gnt_vld),
    .gnt_idx     (gnt_idx),
    .rx_word     (rx_word),
    .act_ptr     (regs[act_idx].cur_ptr),
    .act_size    (regs[act_idx].size),
    .act_idx     (act_idx),
    .per_ack     (per_ack),
    .item_done   (item_done),
    .per_tx_data (per_tx_data),
    .mem_rd      (mem_rd),
    .mem_wr      (mem_wr),
    .mem_addr    (mem_addr),
    .mem_size    (mem_size),
    .mem_wdata   (mem_wdata),
    .mem_rdata   (mem_rdata)
  );

  assign rd_regs = regs[cfg_ch];

  always_comb begin
    case (cfg_sel)
      SEL_CUR_PTR: cfg_rdata = rd_regs.cur_ptr;
      SEL_CUR_CNT: cfg_rdata = word_t'(rd_regs.cur_cnt);
      SEL_NXT_PTR: cfg_rdata = rd_regs.nxt_ptr;
      SEL_NXT_CNT: cfg_rdata = word_t'(rd_regs.nxt_cnt);
      SEL_CTRL:    cfg_rdata = ctrl_word(rd_regs.en, rd_regs.size);
      default:     cfg_rdata = '0;
    endcase
  end

  // R10: only a channel that was eligible can be acknowledged
  p_grant_eligible_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (per_ack & ~elig) == '0);

  // R7: the all-done flag implies the active-done flag
  p_idle_implies_eot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_idle & ~eot) == '0);
endmodule

// File: tb/pbuf_dma_bench.sv
module pbuf_dma_bench;
  localparam int NCH = 4;
  localparam logic [31:0] RD_KEY = 32'h5A5A_0000;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cfg_we = 1'b0;
  logic [1:0]        cfg_ch = '0;
  logic [2:0]        cfg_sel = '0;
  logic [31:0]       cfg_wdata = '0;
  logic [31:0]       cfg_rdata;
  logic [NCH-1:0]    per_req = '0;
  logic [NCH-1:0]    per_ack;
  logic [31:0]       per_tx_data;
  logic [NCH*32-1:0] per_rx_data;
  logic              mem_rd, mem_wr;
  logic [31:0]       mem_addr, mem_wdata, mem_rdata;
  logic [1:0]        mem_size;
  logic [NCH-1:0]    eot, buf_idle;

  int vectors = 0;
  int miscompares = 0;
  int cycles = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  assign mem_rdata   = mem_addr ^ RD_KEY;
  assign per_rx_data = {32'h3333_0003, 32'h2222_0002, 32'h1111_0001, 32'h0000_0000};

  pbuf_dma u_pbuf_dma (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .per_req(per_req), .per_ack(per_ack),
    .per_tx_data(per_tx_data), .per_rx_data(per_rx_data), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_addr(mem_addr), .mem_size(mem_size), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .eot(eot), .buf_idle(buf_idle)
  );

  // size code, start pointer, item count, expected final pointer (R5)
  localparam logic [81:0] VEC [4] = '{
    {2'd0, 32'h0000_1000, 16'd3, 32'h0000_1003},
    {2'd1, 32'h0000_2000, 16'd2, 32'h0000_2004},
    {2'd2, 32'h0000_3000, 16'd4, 32'h0000_3010},
    {2'd3, 32'h0000_4000, 16'd1, 32'h0000_4004}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles == 20000 && !finished) begin
      miscompares++;
      $display("FAIL watchdog: got %0d cycles expected fewer", cycles);
      summary();
    end
  end

  task automatic cfg_write(input int ch, input int sel, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_ch = 2'(ch); cfg_sel = 3'(sel); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic read_chk(input string req, input int ch, input int sel, input logic [31:0] exp);
    @(negedge clk);
    cfg_ch = 2'(ch); cfg_sel = 3'(sel);
    #1 chk(req, cfg_rdata, exp);
  endtask

  // one transmit item with its one-cycle bus checks (R3)
  task automatic tx_item(input int ch, input logic [31:0] addr, input logic [1:0] sz);
    @(negedge clk);
    per_req[ch] = 1'b1;
    #1;
    chk("R3 ack", 32'(per_ack), 32'(1 << ch));
    chk("R3 rd", 32'(mem_rd), 32'd1);
    chk("R3 addr", mem_addr, addr);
    chk("R3 size", 32'(mem_size), 32'(sz));
    chk("R3 data", per_tx_data, addr ^ RD_KEY);
    @(negedge clk);
    per_req[ch] = 1'b0;
  endtask

  function automatic logic [31:0] bstep(input logic [1:0] s);
    if (s == 2'd0) return 32'd1;
    if (s == 2'd1) return 32'd2;
    return 32'd4;
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    #1;
    chk("R1 eot", 32'(eot), 32'hF);
    chk("R1 buf_idle", 32'(buf_idle), 32'hF);
    chk("R1 bus", 32'({mem_rd, mem_wr, |per_ack}), 32'd0);
    for (int c = 0; c < NCH; c++) begin
      for (int s = 0; s < 5; s++) read_chk("R1 regs", c, s, 32'd0);
    end
    // R10: request on a disabled empty channel
    @(negedge clk); per_req = 4'hF;
    #1 chk("R10 idle req", 32'({mem_rd, mem_wr, per_ack}), 32'd0);
    @(negedge clk); per_req = '0;

    // vector table: each size code on channel 0 (R2, R3, R5, R7)
    for (int v = 0; v < 4; v++) begin
      logic [1:0]  sz;
      logic [31:0] p, fin;
      logic [15:0] n;
      {sz, p, n, fin} = VEC[v];
      cfg_write(0, 4, {29'd0, sz, 1'b1});
      cfg_write(0, 0, p);
      cfg_write(0, 1, {16'd0, n});
      read_chk("R2 ctrl", 0, 4, {29'd0, sz, 1'b1});
      read_chk("R2 cur cnt", 0, 1, {16'd0, n});
      chk("R7 eot busy", 32'(eot[0]), 32'd0);
      for (int k = 0; k < int'(n); k++) tx_item(0, p + 32'(k) * bstep(sz), sz);
      read_chk("R5 final ptr", 0, 0, fin);
      read_chk("R5 final cnt", 0, 1, 32'd0);
      chk("R7 eot done", 32'(eot[0]), 32'd1);
      chk("R7 idle done", 32'(buf_idle[0]), 32'd1);
    end
    read_chk("R2 bad code", 0, 7, 32'd0);

    // R8: channels 0 and 2 both pending, channel 2 wins
    cfg_write(0, 4, 32'd5); cfg_write(0, 0, 32'h5000); cfg_write(0, 1, 32'd2);
    cfg_write(2, 4, 32'd5); cfg_write(2, 0, 32'hA000); cfg_write(2, 1, 32'd3);
    @(negedge clk); per_req = 4'b0101;
    #1 chk("R8 winner", 32'(per_ack), 32'b0100);
    chk("R8 addr", mem_addr, 32'hA000);
    @(negedge clk); per_req = '0;

    // R4: receive on channel 1, channel 2 asks during the write cycle
    cfg_write(1, 4, 32'd3); cfg_write(1, 0, 32'h6000); cfg_write(1, 1, 32'd2);
    @(negedge clk); per_req[1] = 1'b1;
    #1 chk("R4 capture ack", 32'(per_ack), 32'b0010);
    chk("R4 no bus", 32'({mem_rd, mem_wr}), 32'd0);
    @(negedge clk); per_req[1] = 1'b0; per_req[2] = 1'b1;
    #1 chk("R4 write", 32'({mem_wr, mem_rd}), 32'b10);
    chk("R4 no ack", 32'(per_ack), 32'd0);
    chk("R4 waddr", mem_addr, 32'h6000);
    chk("R4 wdata", mem_wdata, 32'h1111_0001);
    @(negedge clk);
    #1 chk("R4 next served", 32'(per_ack), 32'b0100);
    chk("R4 next addr", mem_addr, 32'hA004);
    @(negedge clk); per_req = '0;
    read_chk("R5 rx ptr", 1, 0, 32'h6002);
    read_chk("R5 rx cnt", 1, 1, 32'd1);

    // R6: promotion after the last active item
    cfg_write(0, 2, 32'hC000); cfg_write(0, 3, 32'd2); cfg_write(0, 1, 32'd1);
    read_chk("R6 no early promote", 0, 0, 32'h5000);
    tx_item(0, 32'h5000, 2'd2);
    read_chk("R6 ptr", 0, 0, 32'hC000);
    read_chk("R6 cnt", 0, 1, 32'd2);
    read_chk("R6 next cleared", 0, 3, 32'd0);
    chk("R7 eot after promote", 32'(eot[0]), 32'd0);
    tx_item(0, 32'hC000, 2'd2);
    tx_item(0, 32'hC004, 2'd2);
    chk("R7 both empty", 32'({eot[0], buf_idle[0]}), 32'b11);
    // R10: enabled channel with zero count
    @(negedge clk); per_req[0] = 1'b1;
    #1 chk("R10 empty req", 32'({mem_rd, per_ack}), 32'd0);
    @(negedge clk); per_req[0] = 1'b0;
    // R6: standby count written while active is empty
    cfg_write(0, 2, 32'hD000); cfg_write(0, 3, 32'd1);
    read_chk("R6 direct ptr", 0, 0, 32'hD000);
    read_chk("R6 direct cnt", 0, 1, 32'd1);
    read_chk("R6 direct next", 0, 3, 32'd0);

    // R11: standby write during a live item on channel 2
    cfg_write(2, 1, 32'd3);
    @(negedge clk);
    per_req[2] = 1'b1; cfg_we = 1'b1; cfg_ch = 2'd2; cfg_sel = 3'd2; cfg_wdata = 32'hE000;
    #1 chk("R11 item addr", mem_addr, 32'hA008);
    chk("R11 item ack", 32'(per_ack), 32'b0100);
    @(negedge clk); per_req = '0; cfg_we = 1'b0;
    read_chk("R11 cur cnt", 2, 1, 32'd2);
    read_chk("R11 cur ptr", 2, 0, 32'hA00C);
    read_chk("R11 next ptr", 2, 2, 32'hE000);

    // R9: disable lands during a receive item on channel 3
    cfg_write(3, 4, 32'd5); cfg_write(3, 0, 32'h8000); cfg_write(3, 1, 32'd5);
    @(negedge clk);
    per_req[3] = 1'b1; cfg_we = 1'b1; cfg_ch = 2'd3; cfg_sel = 3'd4; cfg_wdata = 32'd4;
    #1 chk("R9 capture", 32'(per_ack), 32'b1000);
    @(negedge clk); per_req[3] = 1'b0; cfg_we = 1'b0;
    #1 chk("R9 write completes", 32'(mem_wr), 32'd1);
    chk("R9 waddr", mem_addr, 32'h8000);
    chk("R9 wdata", mem_wdata, 32'h3333_0003);
    read_chk("R9 kept cnt", 3, 1, 32'd4);
    read_chk("R9 kept ptr", 3, 0, 32'h8004);
    @(negedge clk); per_req[3] = 1'b1;
    #1 chk("R9 stopped", 32'({mem_rd, mem_wr, per_ack}), 32'd0);
    @(negedge clk); per_req = '0;

    finished = 1;
    summary();
  end
endmodule